// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management master for the two-wire PHY management bus. It turns one host request into a complete serial frame. The request carries a read or write command, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a flag that selects a preamble. The block drives a divided management clock and a bidirectional data line, which is split into output, output-enable and input signals. Read data is sampled back from the line. Each request finishes with a one-cycle done pulse and an error flag.

Requests enter through a valid/ready handshake, and the block accepts one only while it is idle. The management clock idles low. Outgoing bits change only while the clock is low, and incoming bits are sampled while it is high. A request addressed to the reserved PHY address 31 never reaches the bus: it completes with the error flag set. On a read, a PHY that fails to pull the second turnaround bit low is reported through the same error flag.

Top module: `mdio_master`

## Requirements
- R1: With `req_pre` set, the frame starts with 32 one bits driven on the line. The whole frame then takes 65 management-clock rising edges, counting the final idle bit.
- R2: With `req_pre` clear, the frame starts with the start field and takes 33 rising edges.
- R3: The start field is the bit pair 0 then 1. The opcode follows it: 1,0 for a read (`req_read`=1) and 0,1 for a write.
- R4: After the opcode come the PHY address and then the register address, 5 bits each, most significant bit first.
- R5: On a write, the two turnaround bits are driven as 1 then 0. The 16 data bits follow, most significant bit first.
- R6: `mdio_oe` is low during both turnaround bits and all 16 data bits of a read. It is also low during the final idle bit of every frame.
- R7: After a read, `rsp_err` equals the line value sampled in the second turnaround bit, so a 1 there means no PHY answered. After a write, `rsp_err` is 0.
- R8: `rsp_rdata` takes the 16 data bits sampled on rising edges, first bit as most significant. It changes only when a read completes.
- R9: `mdc` has a period of CLK_DIV system clocks and is high for CLK_DIV/2 of them. It is low while the block is idle. `mdio_o` and `mdio_oe` never change while `mdc` stays high.
- R10: A request with `req_phy` = 31 produces no `mdc` edge. It is answered two cycles after acceptance with `rsp_done` and `rsp_err` both high.
- R11: `req_ready` is high only when the block is idle. `req_valid` while busy is ignored and neither alters the frame in progress nor starts another one. `rsp_done` lasts exactly one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_pre | input | 1 | Send the 32-bit preamble |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | No response or reserved address |
| rsp_rdata | output | 16 | Data from the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with CLK_DIV=4 and the default 32-bit preamble. At that ratio a full frame takes about 260 system cycles, so every request kind can be driven several times within a short run. It is also the smallest ratio at which a bit change after a falling edge still has a low cycle to settle before the next rise, so the drive and sample timing of R9 is tested at its tightest margin. A line model in the bench answers reads with chosen data, or stays silent, which puts both outcomes of R7 and R8 within reach.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int ST_W     = 2;
  localparam int OP_W     = 2;
  localparam int TA_W     = 2;
  localparam logic [ADDR_W-1:0] RESERVED_PHY = '1;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_REJ
  } ctl_state_t;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] rg;
    logic [DATA_W-1:0] wd;
  } frame_req_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc_q,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      mdc_q    <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= (cnt == CNT_RISE);
      fall_stb <= (cnt == CNT_LAST);
      if (cnt == CNT_LAST) begin
        cnt   <= '0;
        mdc_q <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_RISE) mdc_q <= 1'b1;
      end
    end
  end

  // R9
  strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> mdc_q);

  // R9
  fall_phase_chk: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> !mdc_q);
endmodule

// File: rtl/mdio_bitsel.sv
module mdio_bitsel
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int POS_W   = 7
) (
  input  logic [POS_W-1:0] pos,
  input  frame_req_t       req,
  output logic             bit_o,
  output logic             oe_o
);
  localparam int P_ST   = PRE_LEN;
  localparam int P_OP   = P_ST + ST_W;
  localparam int P_PHY  = P_OP + OP_W;
  localparam int P_REG  = P_PHY + ADDR_W;
  localparam int P_TA   = P_REG + ADDR_W;
  localparam int P_DAT  = P_TA + TA_W;
  localparam int P_IDLE = P_DAT + DATA_W;

  int p;
  int off;

  always_comb begin
    p     = int'(pos);
    off   = 0;
    bit_o = 1'b1;
    oe_o  = 1'b1;
    if (p < P_ST) begin
      bit_o = 1'b1;
    end else if (p < P_OP) begin
      bit_o = (p != P_ST);
    end else if (p < P_PHY) begin
      bit_o = (p == P_OP) ? req.rd : !req.rd;
    end else if (p < P_REG) begin
      off   = ADDR_W - 1 - (p - P_PHY);
      bit_o = req.phy[off];
    end else if (p < P_TA) begin
      off   = ADDR_W - 1 - (p - P_REG);
      bit_o = req.rg[off];
    end else if (p < P_DAT) begin
      oe_o  = !req.rd;
      bit_o = (p == P_TA);
    end else if (p < P_IDLE) begin
      off   = DATA_W - 1 - (p - P_DAT);
      oe_o  = !req.rd;
      bit_o = req.wd[off];
    end else begin
      oe_o  = 1'b0;
      bit_o = 1'b1;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 10,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_pre,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int P_ST   = PRE_LEN;
  localparam int P_TA   = P_ST + ST_W + OP_W + 2 * ADDR_W;
  localparam int P_DAT  = P_TA + TA_W;
  localparam int P_IDLE = P_DAT + DATA_W;
  localparam int POS_W  = $clog2(P_IDLE + 1);
  localparam logic [POS_W-1:0] POS_ST   = POS_W'(P_ST);
  localparam logic [POS_W-1:0] POS_TA2  = POS_W'(P_TA + 1);
  localparam logic [POS_W-1:0] POS_DAT  = POS_W'(P_DAT);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(P_IDLE);

  ctl_state_t        state;
  frame_req_t        cur;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  pos_nxt;
  logic [DATA_W-1:0] rd_shift;
  logic              ta_sample;
  logic              nxt_bit;
  logic              nxt_oe;
  logic              run;
  logic              rise_stb;
  logic              fall_stb;

  assign run       = (state == S_RUN);
  assign req_ready = (state == S_IDLE);
  assign pos_nxt   = pos + 1'b1;

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .mdc_q    (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_bitsel #(.PRE_LEN(PRE_LEN), .POS_W(POS_W)) u_bits (
    .pos   (pos_nxt),
    .req   (cur),
    .bit_o (nxt_bit),
    .oe_o  (nxt_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur       <= '0;
      pos       <= '0;
      rd_shift  <= '0;
      ta_sample <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_phy == RESERVED_PHY) begin
              state <= S_REJ;
            end else begin
              state     <= S_RUN;
              cur.rd    <= req_read;
              cur.phy   <= req_phy;
              cur.rg    <= req_reg;
              cur.wd    <= req_wdata;
              pos       <= req_pre ? '0 : POS_ST;
              rsp_err   <= 1'b0;
              ta_sample <= 1'b0;
              mdio_o    <= req_pre;
              mdio_oe   <= 1'b1;
            end
          end
        end
        S_REJ: begin
          state    <= S_IDLE;
          rsp_done <= 1'b1;
          rsp_err  <= 1'b1;
        end
        S_RUN: begin
          if (rise_stb && cur.rd) begin
            if (pos == POS_TA2) ta_sample <= mdio_i;
            if (pos >= POS_DAT && pos < POS_IDLE)
              rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
          end
          if (fall_stb) begin
            if (pos == POS_IDLE) begin
              state    <= S_IDLE;
              rsp_done <= 1'b1;
              mdio_oe  <= 1'b0;
              mdio_o   <= 1'b1;
              if (cur.rd) begin
                rsp_rdata <= rd_shift;
                rsp_err   <= ta_sample;
              end
            end else begin
              pos     <= pos_nxt;
              mdio_o  <= nxt_bit;
              mdio_oe <= nxt_oe;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mdc);

  // R9
  hold_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R10
  reserved_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_phy == RESERVED_PHY) |=> ##1 (rsp_done && rsp_err && !mdc));

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cur.rd && pos >= POS_W'(P_TA)) |-> !mdio_oe);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && cur.rd && $past(run)) |-> $stable(rsp_rdata));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV = 4;

  typedef struct packed {
    logic        rd;
    logic        pre;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        rsp;
    logic [15:0] pdat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 5'h03, 5'h11, 16'hA5C3, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 5'h1E, 5'h00, 16'h0001, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 5'h01, 5'h02, 16'h0000, 1'b1, 16'h8E17},
    '{1'b1, 1'b0, 5'h10, 5'h1F, 16'h0000, 1'b1, 16'h7001},
    '{1'b1, 1'b1, 5'h05, 5'h04, 16'h0000, 1'b0, 16'h1234},
    '{1'b0, 1'b1, 5'h00, 5'h1F, 16'hFFFF, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_read, req_pre;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #4 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV), .PRE_LEN(32)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_pre(req_pre), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int kcount = 0;
  int rises = 0;
  int hi_cnt = 0;
  int offs = 0;
  logic cur_rd = 1'b0;
  logic phy_rsp = 1'b0;
  logic [15:0] phy_dat = '0;
  logic cap_b [0:64];
  logic cap_e [0:64];
  logic got_done, done_after;
  logic [15:0] exp_rdata;
  int p_now;
  logic phy_line;

  // PHY side of the line: pulled up to 1 unless the PHY answers a read
  always_comb begin
    p_now    = kcount + offs;
    phy_line = 1'b1;
    if (cur_rd && phy_rsp) begin
      if (p_now == 47) phy_line = 1'b0;
      else if (p_now >= 48 && p_now < 64) phy_line = phy_dat[63 - p_now];
    end
  end
  assign mdio_i = mdio_oe ? mdio_o : phy_line;

  always @(negedge mdc) begin
    #1 kcount = kcount + 1;
  end

  always @(posedge mdc) begin
    if (kcount < 65) begin
      cap_b[kcount] = mdio_o;
      cap_e[kcount] = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge clk) if (mdc) hi_cnt = hi_cnt + 1;

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input vec_t v, input int inject);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    kcount  = 0;
    rises   = 0;
    hi_cnt  = 0;
    offs    = v.pre ? 0 : 32;
    cur_rd  = v.rd;
    phy_rsp = v.rsp;
    phy_dat = v.pdat;
    for (int i = 0; i < 65; i++) begin
      cap_b[i] = 1'bx;
      cap_e[i] = 1'bx;
    end
    req_valid = 1'b1;
    req_read  = v.rd;
    req_pre   = v.pre;
    req_phy   = v.phy;
    req_reg   = v.rg;
    req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject > 0) begin
      repeat (inject) @(negedge clk);
      check("R11", "ready while busy", {31'd0, req_ready}, 32'd0);
      req_valid = 1'b1;
      req_read  = ~v.rd;
      req_phy   = 5'h0A;
      req_reg   = 5'h15;
      req_wdata = 16'h5A5A;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    for (int n = 0; n < 2000 && !rsp_done; n++) @(negedge clk);
    got_done = rsp_done;
    @(negedge clk);
    done_after = rsp_done;
  endtask

  task automatic check_frame(input vec_t v);
    logic [64:0] eb;
    logic [64:0] ee;
    int mism;
    eb = {32'hFFFF_FFFF, 2'b01, (v.rd ? 2'b10 : 2'b01), v.phy, v.rg,
          (v.rd ? 2'b00 : 2'b10), (v.rd ? 16'h0 : v.wd), 1'b0};
    ee = {32'hFFFF_FFFF, 2'b11, 2'b11, 10'h3FF,
          (v.rd ? 2'b00 : 2'b11), (v.rd ? 16'h0 : 16'hFFFF), 1'b0};
    mism = 0;
    for (int p = offs; p <= 64; p++) begin
      if (cap_e[p - offs] !== ee[64 - p]) mism++;
      else if (ee[64 - p] && cap_b[p - offs] !== eb[64 - p]) mism++;
    end
    // R1 R2: edge count; R3 R4 R5 R6: bits and enables per position
    check(v.pre ? "R1" : "R2", "rising edges", rises, 65 - offs);
    check("R3 R4 R5 R6", "frame mismatches", mism, 0);
    check("R9", "mdc high cycles", hi_cnt, rises * (DIV / 2));
    check("R11", "done seen / one cycle", {30'd0, got_done, done_after}, 32'd2);
    check("R7", "err flag", {31'd0, rsp_err}, {31'd0, v.rd & ~v.rsp});
  endtask

  initial begin
    int dn;
    int rs;
    vec_t v;
    rst = 1'b1;
    req_valid = 1'b0; req_read = 1'b0; req_pre = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    exp_rdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R9, R11)
    check("R9", "mdc after reset", {31'd0, mdc}, 32'd0);
    check("R6", "oe after reset", {31'd0, mdio_oe}, 32'd0);
    check("R11", "ready/done after reset", {30'd0, req_ready, rsp_done}, 32'd2);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      run_req(v, 0);
      check_frame(v);
      if (v.rd) exp_rdata = v.rsp ? v.pdat : 16'hFFFF;
      check("R8", "read data", rsp_rdata, exp_rdata);
    end

    // R10: reserved PHY address, read and write
    v = '{1'b1, 1'b1, 5'h1F, 5'h01, 16'h0, 1'b1, 16'hBEEF};
    run_req(v, 0);
    check("R10", "edges on reserved", rises, 0);
    check("R10", "done+err", {30'd0, got_done, rsp_err}, 32'd3);
    check("R8", "rdata kept on reject", rsp_rdata, exp_rdata);
    v = '{1'b0, 1'b0, 5'h1F, 5'h01, 16'h1, 1'b0, 16'h0};
    run_req(v, 0);
    check("R10", "edges on reserved write", rises, 0);
    check("R10", "err on reserved write", {31'd0, rsp_err}, 32'd1);

    // R11: request offered while busy is ignored
    v = '{1'b0, 1'b0, 5'h06, 5'h09, 16'hC0DE, 1'b0, 16'h0};
    run_req(v, 20);
    check_frame(v);
    rs = rises;
    dn = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rsp_done) dn++;
    end
    check("R11", "extra done after ignored request", dn, 0);
    check("R11", "extra edges after ignored request", rises, rs);
    check("R8", "rdata kept over writes", rsp_rdata, exp_rdata);

    // back-to-back reads keep working after the above
    v = '{1'b1, 1'b0, 5'h02, 5'h03, 16'h0, 1'b1, 16'h0F0F};
    run_req(v, 0);
    check_frame(v);
    check("R8", "read data after ignore", rsp_rdata, 16'h0F0F);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule